// File: doc/BRIEF.md
# Adapter Memory Window Decoder

This block sits between a host byte bus and the pieces of a small SCSI host adapter that share one 16 KB memory window. Each host access carries an address, a read strobe or a write strobe, and a write byte. The block looks at the window offset, which is the low 14 address bits. It then steers the access to one of several places: a boot ROM, a 128-byte scratch RAM inside the block, an 8-bit control register inside the block, a status byte supplied from outside, a bank of eight controller registers, or a data-transfer window.

The boot ROM, the controller and the transfer buffer live outside the block. For each of them the block raises a select strobe during the access cycle. The controller also receives a 3-bit register index. Each of these outside targets returns its read byte on its own input. The block captures the chosen byte one clock after the read strobe. A read that lands on no target returns all ones.

Top module: `adapter_window`

## Requirements
- R1: Only address bits [13:0] take part in decoding. An address whose upper bits differ behaves exactly like the same offset with those bits cleared.
- R2: A read at offsets 0x0000 to 0x17FF raises `rom_sel` and returns `rom_rdata`, but only while `boot_en` is 1. While `boot_en` is 0 it raises no strobe and returns 0xFF.
- R3: Offsets 0x1800 to 0x187F reach a 128-byte scratch RAM, indexed by offset bits [6:0]. A byte written there reads back unchanged.
- R4: Offsets 0x1C00 to 0x1C1F read and write one 8-bit control register, all 32 offsets aliasing. Its value is driven on `ctrl_q`, which is 0x00 after reset.
- R5: A read at offsets 0x1C20 to 0x1C3F returns `status_in`.
- R6: Offsets 0x1D00 to 0x1DFF raise `ctl_sel` for reads and writes. `ctl_idx` equals offset bits [7:5], so the eight controller registers are spaced 32 bytes apart. A read returns `ctl_rdata`.
- R7: Offsets 0x1E00 to 0x1FFF raise `xfer_sel` for reads and writes, and a read returns `xfer_rdata`.
- R8: A read at any other offset returns 0xFF and raises no strobe. These offsets are 0x1880 to 0x1BFF, 0x1C40 to 0x1CFF and 0x2000 to 0x3FFF.
- R9: Writes to the ROM region and the status region are ignored. They raise no strobe and leave the scratch RAM and `ctrl_q` unchanged.
- R10: `host_rdata` is loaded at the clock edge that ends a read cycle and holds its value when there is no read. It is 0x00 after reset.
- R11: At most one of `rom_sel`, `ctl_sel` and `xfer_sel` is high in any cycle. A cycle with both strobes high is treated as a read only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rdata | output | 8 | Registered read byte |
| boot_en | input | 1 | Enables the ROM region |
| rom_sel | output | 1 | ROM read select |
| rom_rdata | input | 8 | ROM byte for the current address |
| status_in | input | 8 | Status byte |
| ctrl_q | output | 8 | Control register value |
| ctl_sel | output | 1 | Controller register select |
| ctl_idx | output | 3 | Controller register index |
| ctl_rdata | input | 8 | Controller read byte |
| xfer_sel | output | 1 | Transfer window select |
| xfer_rdata | input | 8 | Transfer window read byte |

## Verification
A wrong region boundary or a wrong index bit shows on the very next cycle: a read near that edge returns the wrong source's byte in `host_rdata`. A misdecoded write shows at once as a select strobe that should be low. A scratch RAM or control register hit by a stray write keeps the bad value until it is read. That read shows the damage one cycle later, or at once on `ctrl_q`. For this reason the bench sweeps every offset with the ROM enabled and again with it disabled, after the stray writes have had their chance.

// File: rtl/adapter_window.sv
module adapter_window #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [7:0]        host_rdata,
  input  logic              boot_en,
  output logic              rom_sel,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        status_in,
  output logic [7:0]        ctrl_q,
  output logic              ctl_sel,
  output logic [2:0]        ctl_idx,
  input  logic [7:0]        ctl_rdata,
  output logic              xfer_sel,
  input  logic [7:0]        xfer_rdata
);
  localparam int OFS_W = 14;
  localparam int RAM_N = 128;

  logic [OFS_W-1:0] ofs;
  logic rd, wr, acc;
  logic in_rom, in_ram, in_ctrl, in_stat, in_ctl, in_xfer;
  logic [7:0] ram [RAM_N];
  logic [7:0] rd_mux;
  logic unused_hi;

  assign ofs       = host_addr[OFS_W-1:0];
  assign unused_hi = ^host_addr[ADDR_W-1:OFS_W];
  assign rd        = host_rd;
  assign wr        = host_wr & ~host_rd;
  assign acc       = rd | wr;

  assign in_rom  = ofs < 14'h1800;
  assign in_ram  = ofs[13:7] == 7'h30;
  assign in_ctrl = ofs[13:5] == 9'h0E0;
  assign in_stat = ofs[13:5] == 9'h0E1;
  assign in_ctl  = ofs[13:8] == 6'h1D;
  assign in_xfer = ofs[13:9] == 5'h0F;

  assign rom_sel  = rd & in_rom & boot_en;
  assign ctl_sel  = acc & in_ctl;
  assign xfer_sel = acc & in_xfer;
  assign ctl_idx  = ofs[7:5];

  always_ff @(posedge clk)
    if (wr && in_ram) ram[ofs[6:0]] <= host_wdata;

  always_ff @(posedge clk)
    if (!rst_n)                ctrl_q <= 8'h00;
    else if (wr && in_ctrl)    ctrl_q <= host_wdata;

  always_comb begin
    rd_mux = 8'hFF;
    if (in_rom && boot_en) rd_mux = rom_rdata;
    else if (in_ram)       rd_mux = ram[ofs[6:0]];
    else if (in_ctrl)      rd_mux = ctrl_q;
    else if (in_stat)      rd_mux = status_in;
    else if (in_ctl)       rd_mux = ctl_rdata;
    else if (in_xfer)      rd_mux = xfer_rdata;
  end

  always_ff @(posedge clk)
    if (!rst_n)      host_rdata <= 8'h00;
    else if (rd)     host_rdata <= rd_mux;

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ctl_sel, xfer_sel}));

  // R9
  rom_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd) |-> !rom_sel);

  // R5
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr[13:0] >= 14'h1C20 && host_addr[13:0] < 14'h1C40)
      |=> host_rdata == $past(status_in));

  // R8
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && ((host_addr[13:0] >= 14'h1880 && host_addr[13:0] < 14'h1C00) ||
                 (host_addr[13:0] >= 14'h1C40 && host_addr[13:0] < 14'h1D00) ||
                  host_addr[13])) |=> host_rdata == 8'hFF);

  // R4
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && host_addr[13:0] >= 14'h1C00 && host_addr[13:0] < 14'h1C20)
      |=> ctrl_q == $past(host_wdata));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/tb_adapter_window.sv
module tb_adapter_window;
  localparam int ADDR_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_rd = 1'b0, host_wr = 1'b0, boot_en = 1'b1;
  logic [7:0] host_rdata, ctrl_q, rom_rdata, ctl_rdata, xfer_rdata;
  logic [7:0] status_in = 8'h96;
  logic rom_sel, ctl_sel, xfer_sel;
  logic [2:0] ctl_idx;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign rom_rdata  = host_addr[7:0] ^ 8'h5A;
  assign ctl_rdata  = {5'b10100, host_addr[7:5]};
  assign xfer_rdata = ~host_addr[7:0];

  adapter_window #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .boot_en(boot_en), .rom_sel(rom_sel), .rom_rdata(rom_rdata),
    .status_in(status_in), .ctrl_q(ctrl_q), .ctl_sel(ctl_sel),
    .ctl_idx(ctl_idx), .ctl_rdata(ctl_rdata), .xfer_sel(xfer_sel),
    .xfer_rdata(xfer_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] ram_pat(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [ADDR_W-1:0] full(input int ofs);
    logic [5:0] hi;
    hi = 6'(ofs[5:0] ^ 6'h2B);
    return {hi, 14'(ofs)};
  endfunction

  function automatic logic [7:0] exp_rd(input int o, input bit be, input logic [7:0] cv);
    if (o < 'h1800) return be ? (8'(o) ^ 8'h5A) : 8'hFF;
    if (o >= 'h1800 && o < 'h1880) return ram_pat(o - 'h1800);
    if (o >= 'h1C00 && o < 'h1C20) return cv;
    if (o >= 'h1C20 && o < 'h1C40) return 8'h96;
    if (o >= 'h1D00 && o < 'h1E00) return {5'b10100, 3'((o - 'h1D00) / 32)};
    if (o >= 'h1E00 && o < 'h2000) return ~8'(o);
    return 8'hFF;
  endfunction

  task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [ADDR_W-1:0] a, output logic [7:0] d,
                         output logic rs, output logic cs, output logic xs, output logic [2:0] ix);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1; host_wr = 1'b0;
    #1; rs = rom_sel; cs = ctl_sel; xs = xfer_sel; ix = ctl_idx;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  initial begin
    logic [7:0] d;
    logic rs, cs, xs;
    logic [2:0] ix;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(host_rdata == 8'h00, "R10 reset rdata", 16'(host_rdata), 16'h00);
    chk(ctrl_q == 8'h00, "R4 reset ctrl", 16'(ctrl_q), 16'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 128; i++) wr_byte(full('h1800 + i), ram_pat(i));
    wr_byte(full('h1C05), 8'hA7);
    chk(ctrl_q == 8'hA7, "R4 ctrl write", 16'(ctrl_q), 16'hA7);

    @(negedge clk);
    host_addr = full('h0100); host_wdata = 8'h00; host_wr = 1'b1; #1;
    chk(!rom_sel && !ctl_sel && !xfer_sel, "R9 rom write strobe", 16'({rom_sel, ctl_sel, xfer_sel}), 16'h0);
    @(negedge clk);
    host_addr = full('h1C25); #1;
    chk(!rom_sel && !ctl_sel && !xfer_sel, "R9 status write strobe", 16'({rom_sel, ctl_sel, xfer_sel}), 16'h0);
    @(negedge clk);
    host_wr = 1'b0;
    chk(ctrl_q == 8'hA7, "R9 ctrl unchanged", 16'(ctrl_q), 16'hA7);

    @(negedge clk);
    host_addr = full('h1D65); host_wr = 1'b1; #1;
    chk(ctl_sel && ctl_idx == 3'd3, "R6 write select", 16'({ctl_sel, ctl_idx}), 16'h0B);
    @(negedge clk);
    host_addr = full('h1E10); #1;
    chk(xfer_sel && !ctl_sel, "R7 write select", 16'({xfer_sel, ctl_sel}), 16'h2);
    @(negedge clk);
    host_wr = 1'b0;

    @(negedge clk);
    host_addr = full('h1C10); host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'h11;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    chk(ctrl_q == 8'hA7 && host_rdata == 8'hA7, "R11 read wins", 16'({ctrl_q, host_rdata}), 16'hA7A7);

    for (int pass = 0; pass < 2; pass++) begin
      boot_en = (pass == 0);
      for (int o = 0; o < 16384; o++) begin
        logic [7:0] e;
        bit ers, ecs, exs;
        rd_byte(full(o), d, rs, cs, xs, ix);
        e = exp_rd(o, boot_en, 8'hA7);
        chk(d == e, "R1 R2 R3 R5 R6 R7 R8 read data", 16'(d), 16'(e));
        ers = (o < 'h1800) && boot_en;
        ecs = (o >= 'h1D00 && o < 'h1E00);
        exs = (o >= 'h1E00 && o < 'h2000);
        chk(rs == ers && cs == ecs && xs == exs && (!ecs || ix == 3'(o >> 5)),
            "R11 strobes", 16'({rs, cs, xs, ix}), 16'({ers, ecs, exs, ecs ? 3'(o >> 5) : ix}));
      end
    end

    rd_byte(full('h1C20), d, rs, cs, xs, ix);
    held = host_rdata;
    status_in = 8'h3C;
    repeat (3) @(negedge clk);
    chk(host_rdata == held, "R10 hold without read", 16'(host_rdata), 16'(held));
    rd_byte(full('h1C3F), d, rs, cs, xs, ix);
    chk(d == 8'h3C, "R5 new status", 16'(d), 16'h3C);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule